// File: doc/BRIEF.md
# Exception Entry Controller

This block decides which exception a simple in-order core takes next. It gathers the reset requests, the machine-check sources, the two maskable asynchronous sources (an external interrupt level and a latched decrementer request) and the program-type faults of the instruction that is completing. It then picks one by fixed priority. When it takes an exception it raises a one-cycle vector strobe. The vector address is a fixed offset per exception kind added to a base. In the same cycle it loads the return address and a status snapshot with cause bits into two save registers, and it updates the status register.

A machine check that arrives while machine checks are disabled does not vector. It sends the controller into a sticky checkstop state instead, and only a hard reset request ends that state. An external or decrementer request does not vector at once. The controller first stalls dispatch and asks the pipeline to drain. It vectors only when the pipeline reports that it is empty. A fault raised by an instruction completing during the drain is taken first.

The controller has three states. RUN is normal operation. DRAIN holds dispatch and waits for the pipeline to empty. CKSTOP is the halted state. The transitions are:
- RUN to DRAIN when an enabled asynchronous request is present and nothing else is taken.
- RUN or DRAIN to CKSTOP when a machine check arrives with the enable bit clear.
- DRAIN to RUN on any take, or when the drain completes with no enabled source left.
- CKSTOP to RUN on a hard reset request, which takes the reset vector.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After power-on reset the state is RUN. `vec_valid`, `dispatch_stall`, `drain_req` and `checkstop` are 0, and `msr` equals `MSR_RST` (default 0x02, machine-check enable set).
- R2: A take raises `vec_valid` for one cycle, one clock edge after the inputs that cause it are sampled. `vec_addr` is `VEC_BASE` plus the offset for the kind: reset 0x100, machine check 0x200, external 0x500, program 0x700, FP unavailable 0x800, decrementer 0x900.
- R3: A system reset is taken when either `soft_rst_req` or `hard_rst_req` is 1.
- R4: With `msr[1]` (ME) set, a machine check is taken for `mchk_pin`, or for `bus_terr` together with `bus_terr_qual`. `bus_terr` alone is ignored.
- R5: A machine check with ME clear enters CKSTOP and produces no vector. In CKSTOP, `checkstop` and `dispatch_stall` are 1, and soft reset and instruction faults are ignored. `hard_rst_req` takes the reset vector and returns the controller to RUN.
- R6: On every take, `msr` clears bits EE(5), PR(4), ME(1) and RI(0) and keeps FE1(3) and FE0(2). `srr1[5:0]` receives the previous `msr`.
- R7: With EE set, `ext_irq` moves the controller to DRAIN, where `dispatch_stall` and `drain_req` are 1. Vector 0x500 follows the edge at which `drain_done` is sampled, and `srr0` is `resume_pc`.
- R8: A program fault of an instruction completing during DRAIN is taken instead of the pending external interrupt.
- R9: A program fault is raised for a valid instruction in any of these cases: it is illegal; it is a trap; it is a privileged op or a move with the top SPR bit set while PR is 1; or `fp_fex` is set while FE0 or FE1 is 1. `srr1[11:8]` = {fpe, illegal, privileged, trap}, and `srr0` = `ins_pc`.
- R10: With `state_lost` set, a reset or machine-check take clears the RI copy in `srr1[0]`. Other takes copy RI unchanged.
- R11: The priority is reset, then machine check, then program, then FP unavailable, then external, then decrementer. With EE clear, the asynchronous sources cause neither a drain nor a vector.
- R12: A `dec_req` pulse stays pending while EE is clear and is taken once after EE is set. The take clears the pending request.
- R13: `msr_wr` loads `msr_wdata` into `msr` on the next edge unless a take happens at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| soft_rst_req | input | 1 | Soft reset request |
| hard_rst_req | input | 1 | Hard reset request; also exits checkstop |
| mchk_pin | input | 1 | Machine-check input pin |
| bus_terr | input | 1 | Bus transfer-error flag |
| bus_terr_qual | input | 1 | Qualifier for the transfer-error flag |
| state_lost | input | 1 | Saved state unreliable for this reset or machine check |
| ext_irq | input | 1 | External interrupt level |
| dec_req | input | 1 | Decrementer request pulse |
| ins_valid | input | 1 | An instruction is completing |
| ins_pc | input | AW | Address of the completing instruction |
| ins_illegal | input | 1 | Illegal opcode |
| ins_priv_op | input | 1 | Privileged operation |
| ins_spr_move | input | 1 | Special-register move |
| ins_spr_top | input | 1 | Top bit of the SPR field of that move |
| ins_trap | input | 1 | Trap condition met |
| ins_fp_off | input | 1 | FP instruction while the FP unit is unavailable |
| fp_fex | input | 1 | FP summary enabled-exception flag |
| resume_pc | input | AW | Next address to dispatch |
| drain_done | input | 1 | Pipeline reports no instruction in flight |
| msr_wr | input | 1 | Status register write strobe |
| msr_wdata | input | 6 | Status register write data |
| dispatch_stall | output | 1 | Hold dispatch |
| drain_req | output | 1 | Request to drain in-flight instructions |
| vec_valid | output | 1 | One-cycle take strobe |
| vec_addr | output | AW | Handler vector address |
| srr0 | output | AW | Saved return address |
| srr1 | output | 12 | Saved status and cause bits |
| msr | output | 6 | Status register |
| checkstop | output | 1 | Checkstop state |

## Verification
Every take shows up one clock edge after its inputs are sampled, through the vector strobe, the vector address, both save registers and the status register. The drain outputs `dispatch_stall` and `drain_req` also follow one edge after the external or decrementer request is seen. An external or decrementer vector needs one more edge after `drain_done`. The bench changes inputs only on falling edges, advances exactly one rising edge per step, and reads the outputs at the next falling edge. Each expected value is therefore compared in the cycle where it first becomes due. A second step after each take confirms that the strobe has dropped.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int MSR_W   = 6;
    localparam int CAUSE_W = 4;
    localparam int SRR1_W  = 12;
    localparam int OFF_W   = 12;

    localparam int B_RI  = 0;
    localparam int B_ME  = 1;
    localparam int B_FE0 = 2;
    localparam int B_FE1 = 3;
    localparam int B_PR  = 4;
    localparam int B_EE  = 5;

    typedef enum logic [2:0] {
        EK_NONE,
        EK_RESET,
        EK_MCHK,
        EK_PROG,
        EK_FPU,
        EK_EXT,
        EK_DEC
    } exc_kind_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_DRAIN,
        ST_CKSTOP
    } ctl_state_e;

    function automatic logic [OFF_W-1:0] vec_offset(exc_kind_e k);
        logic [OFF_W-1:0] o;
        unique case (k)
            EK_RESET: o = 12'h100;
            EK_MCHK:  o = 12'h200;
            EK_EXT:   o = 12'h500;
            EK_PROG:  o = 12'h700;
            EK_FPU:   o = 12'h800;
            EK_DEC:   o = 12'h900;
            default:  o = 12'h000;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/exc_entry_arb.sv
module exc_entry_arb
    import exc_entry_pkg::*;
(
    input  logic      rst_req,
    input  logic      mchk_req,
    input  logic      prog_req,
    input  logic      fpu_req,
    input  logic      ext_req,
    input  logic      dec_req,
    output exc_kind_e kind
);

    always_comb begin
        if (rst_req)
            kind = EK_RESET;
        else if (mchk_req)
            kind = EK_MCHK;
        else if (prog_req)
            kind = EK_PROG;
        else if (fpu_req)
            kind = EK_FPU;
        else if (ext_req)
            kind = EK_EXT;
        else if (dec_req)
            kind = EK_DEC;
        else
            kind = EK_NONE;
    end

endmodule

// File: rtl/exc_entry_save.sv
module exc_entry_save
    import exc_entry_pkg::*;
#(
    parameter int AW = 32
) (
    input  exc_kind_e          kind,
    input  logic [MSR_W-1:0]   msr_cur,
    input  logic               state_lost,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [AW-1:0]      ins_pc,
    input  logic [AW-1:0]      resume_pc,
    output logic [AW-1:0]      srr0_nxt,
    output logic [SRR1_W-1:0]  srr1_nxt,
    output logic [MSR_W-1:0]   msr_nxt
);

    localparam int PAD_W = SRR1_W - CAUSE_W - MSR_W;

    logic [MSR_W-1:0]   snap;
    logic [CAUSE_W-1:0] cause_sel;
    logic               precise;
    logic               unrecov;

    always_comb begin
        precise   = (kind == EK_PROG) || (kind == EK_FPU);
        unrecov   = state_lost && ((kind == EK_RESET) || (kind == EK_MCHK));
        cause_sel = (kind == EK_PROG) ? cause : '0;

        snap = msr_cur;
        if (unrecov)
            snap[B_RI] = 1'b0;

        srr0_nxt = precise ? ins_pc : resume_pc;
        srr1_nxt = {cause_sel, {PAD_W{1'b0}}, snap};

        msr_nxt        = msr_cur;
        msr_nxt[B_EE]  = 1'b0;
        msr_nxt[B_PR]  = 1'b0;
        msr_nxt[B_ME]  = 1'b0;
        msr_nxt[B_RI]  = 1'b0;
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int                AW        = 32,
    parameter logic [AW-1:0]     VEC_BASE  = 32'hFFF0_0000,
    parameter logic [MSR_W-1:0]  MSR_RST   = 6'h02
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                soft_rst_req,
    input  logic                hard_rst_req,
    input  logic                mchk_pin,
    input  logic                bus_terr,
    input  logic                bus_terr_qual,
    input  logic                state_lost,
    input  logic                ext_irq,
    input  logic                dec_req,
    input  logic                ins_valid,
    input  logic [AW-1:0]       ins_pc,
    input  logic                ins_illegal,
    input  logic                ins_priv_op,
    input  logic                ins_spr_move,
    input  logic                ins_spr_top,
    input  logic                ins_trap,
    input  logic                ins_fp_off,
    input  logic                fp_fex,
    input  logic [AW-1:0]       resume_pc,
    input  logic                drain_done,
    input  logic                msr_wr,
    input  logic [MSR_W-1:0]    msr_wdata,
    output logic                dispatch_stall,
    output logic                drain_req,
    output logic                vec_valid,
    output logic [AW-1:0]       vec_addr,
    output logic [AW-1:0]       srr0,
    output logic [SRR1_W-1:0]   srr1,
    output logic [MSR_W-1:0]    msr,
    output logic                checkstop
);

    localparam int HI_W = AW - OFF_W;

    ctl_state_e          state, state_nxt;
    exc_kind_e           kind;
    logic                dec_pend;
    logic                halted;
    logic                mchk_cond, rst_cond;
    logic                priv_hit, fpe_hit;
    logic [CAUSE_W-1:0]  cause;
    logic                prog_cond, fpu_cond;
    logic                ext_cond, dec_cond;
    logic                async_ok;
    logic                ckstop_go, take;
    logic [AW-1:0]       srr0_nxt;
    logic [SRR1_W-1:0]   srr1_nxt;
    logic [MSR_W-1:0]    msr_nxt;

    // request qualification
    always_comb begin
        halted    = (state == ST_CKSTOP);
        mchk_cond = mchk_pin | (bus_terr & bus_terr_qual);
        rst_cond  = halted ? hard_rst_req : (soft_rst_req | hard_rst_req);
        priv_hit  = msr[B_PR] & (ins_priv_op | (ins_spr_move & ins_spr_top));
        fpe_hit   = (msr[B_FE0] | msr[B_FE1]) & fp_fex;
        cause     = {fpe_hit, ins_illegal, priv_hit, ins_trap};
        prog_cond = ins_valid & (|cause) & ~halted;
        fpu_cond  = ins_valid & ins_fp_off & ~halted;
        ext_cond  = ext_irq & msr[B_EE];
        dec_cond  = dec_pend & msr[B_EE];
        async_ok  = (state == ST_DRAIN) & drain_done;
    end

    exc_entry_arb u_arb (
        .rst_req  (rst_cond),
        .mchk_req (mchk_cond & ~halted),
        .prog_req (prog_cond),
        .fpu_req  (fpu_cond),
        .ext_req  (ext_cond & async_ok),
        .dec_req  (dec_cond & async_ok),
        .kind     (kind)
    );

    exc_entry_save #(.AW(AW)) u_save (
        .kind       (kind),
        .msr_cur    (msr),
        .state_lost (state_lost),
        .cause      (cause),
        .ins_pc     (ins_pc),
        .resume_pc  (resume_pc),
        .srr0_nxt   (srr0_nxt),
        .srr1_nxt   (srr1_nxt),
        .msr_nxt    (msr_nxt)
    );

    always_comb begin
        ckstop_go = (kind == EK_MCHK) & ~msr[B_ME];
        take      = (kind != EK_NONE) & ~ckstop_go;
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN: begin
                if (ckstop_go)
                    state_nxt = ST_CKSTOP;
                else if (take)
                    state_nxt = ST_RUN;
                else if (ext_cond | dec_cond)
                    state_nxt = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (ckstop_go)
                    state_nxt = ST_CKSTOP;
                else if (take || drain_done)
                    state_nxt = ST_RUN;
            end
            ST_CKSTOP: begin
                if (take)
                    state_nxt = ST_RUN;
            end
            default: state_nxt = ST_RUN;
        endcase
    end

    // state register and entry-side registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_RUN;
            vec_valid <= 1'b0;
            vec_addr  <= VEC_BASE;
            srr0      <= '0;
            srr1      <= '0;
            msr       <= MSR_RST;
            dec_pend  <= 1'b0;
        end else begin
            state     <= state_nxt;
            vec_valid <= take;
            dec_pend  <= dec_req | (dec_pend & ~(take & (kind == EK_DEC)));
            if (take) begin
                vec_addr <= VEC_BASE | {{HI_W{1'b0}}, vec_offset(kind)};
                srr0     <= srr0_nxt;
                srr1     <= srr1_nxt;
                msr      <= msr_nxt;
            end else if (msr_wr) begin
                msr      <= msr_wdata;
            end
        end
    end

    // state-decoded outputs
    always_comb begin
        dispatch_stall = 1'b0;
        drain_req      = 1'b0;
        checkstop      = 1'b0;
        unique case (state)
            ST_RUN:    ;
            ST_DRAIN:  begin dispatch_stall = 1'b1; drain_req = 1'b1; end
            ST_CKSTOP: begin dispatch_stall = 1'b1; checkstop = 1'b1; end
            default:   ;
        endcase
    end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int AW = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hard_rst_req,
    input logic             vec_valid,
    input logic [AW-1:0]    vec_addr,
    input logic             drain_req,
    input logic             dispatch_stall,
    input logic             checkstop,
    input logic [MSR_W-1:0] msr
);

    // R5
    ckstop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (checkstop && !hard_rst_req) |=> checkstop);

    // R5
    ckstop_novec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        checkstop |-> !vec_valid);

    // R2
    vec_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_addr[7:0] == 8'h00 && vec_addr[11:8] != 4'h0
                       && vec_addr[11:8] <= 4'h9));

    // R6
    entry_msr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (!msr[B_ME] && !msr[B_EE] && !msr[B_PR] && !msr[B_RI]));

    // R7
    drain_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drain_req |-> dispatch_stall);

    // R7
    ext_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_addr[11:8] == 4'h5) |-> $past(drain_req));

endmodule

bind exc_entry_ctrl exc_entry_chk #(.AW(AW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .hard_rst_req   (hard_rst_req),
    .vec_valid      (vec_valid),
    .vec_addr       (vec_addr),
    .drain_req      (drain_req),
    .dispatch_stall (dispatch_stall),
    .checkstop      (checkstop),
    .msr            (msr)
);

// File: tb/exc_entry_ctrl_test.sv
`timescale 1ns/1ps
module exc_entry_ctrl_test;

    localparam int AW = 32;
    localparam logic [31:0] BASE = 32'hFFF0_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst_req, hard_rst_req, mchk_pin, bus_terr, bus_terr_qual;
    logic state_lost, ext_irq, dec_req, ins_valid;
    logic [AW-1:0] ins_pc, resume_pc;
    logic ins_illegal, ins_priv_op, ins_spr_move, ins_spr_top, ins_trap;
    logic ins_fp_off, fp_fex, drain_done, msr_wr;
    logic [5:0] msr_wdata;
    logic dispatch_stall, drain_req, vec_valid, checkstop;
    logic [AW-1:0] vec_addr, srr0;
    logic [11:0] srr1;
    logic [5:0] msr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    exc_entry_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .soft_rst_req(soft_rst_req), .hard_rst_req(hard_rst_req),
        .mchk_pin(mchk_pin), .bus_terr(bus_terr), .bus_terr_qual(bus_terr_qual),
        .state_lost(state_lost), .ext_irq(ext_irq), .dec_req(dec_req),
        .ins_valid(ins_valid), .ins_pc(ins_pc), .ins_illegal(ins_illegal),
        .ins_priv_op(ins_priv_op), .ins_spr_move(ins_spr_move),
        .ins_spr_top(ins_spr_top), .ins_trap(ins_trap), .ins_fp_off(ins_fp_off),
        .fp_fex(fp_fex), .resume_pc(resume_pc), .drain_done(drain_done),
        .msr_wr(msr_wr), .msr_wdata(msr_wdata),
        .dispatch_stall(dispatch_stall), .drain_req(drain_req),
        .vec_valid(vec_valid), .vec_addr(vec_addr), .srr0(srr0), .srr1(srr1),
        .msr(msr), .checkstop(checkstop)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        soft_rst_req = 0; hard_rst_req = 0; mchk_pin = 0; bus_terr = 0;
        bus_terr_qual = 0; state_lost = 0; ext_irq = 0; dec_req = 0;
        ins_valid = 0; ins_illegal = 0; ins_priv_op = 0; ins_spr_move = 0;
        ins_spr_top = 0; ins_trap = 0; ins_fp_off = 0; fp_fex = 0;
        drain_done = 0; msr_wr = 0; msr_wdata = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic msr_set(input logic [5:0] v);
        msr_wr = 1; msr_wdata = v;
        step();
        msr_wr = 0;
    endtask

    task automatic t_reset_state();
        chk("R1 vec_valid", vec_valid, 0);
        chk("R1 stall", dispatch_stall, 0);
        chk("R1 drain_req", drain_req, 0);
        chk("R1 checkstop", checkstop, 0);
        chk("R1 msr", msr, 6'h02);
        msr_set(6'h15);
        chk("R13 msr write", msr, 6'h15);
        msr_set(6'h02);
    endtask

    task automatic t_resets();
        soft_rst_req = 1; step(); soft_rst_req = 0;
        chk("R3 soft valid", vec_valid, 1);
        chk("R2 reset vector", vec_addr, BASE | 32'h100);
        chk("R6 msr after entry", msr, 6'h00);
        chk("R6 srr1 snapshot", srr1, 12'h002);
        chk("R2 srr0 resume", srr0, 32'h1000);
        step();
        chk("R2 strobe one cycle", vec_valid, 0);
        hard_rst_req = 1; step(); hard_rst_req = 0;
        chk("R3 hard valid", vec_valid, 1);
        chk("R3 hard vector", vec_addr, BASE | 32'h100);
    endtask

    task automatic t_mchk();
        msr_set(6'h02);
        bus_terr = 1; step();
        chk("R4 unqualified ignored", vec_valid, 0);
        chk("R4 no checkstop", checkstop, 0);
        bus_terr_qual = 1; step(); bus_terr = 0; bus_terr_qual = 0;
        chk("R4 bus mchk valid", vec_valid, 1);
        chk("R4 bus mchk vector", vec_addr, BASE | 32'h200);
        chk("R4 srr1", srr1, 12'h002);
        msr_set(6'h02);
        mchk_pin = 1; step(); mchk_pin = 0;
        chk("R4 pin mchk vector", vec_addr, BASE | 32'h200);
        chk("R4 pin mchk valid", vec_valid, 1);
    endtask

    task automatic t_ckstop();
        msr_set(6'h00);
        mchk_pin = 1; step(); mchk_pin = 0;
        chk("R5 checkstop", checkstop, 1);
        chk("R5 no vector", vec_valid, 0);
        chk("R5 stall", dispatch_stall, 1);
        soft_rst_req = 1; step(); soft_rst_req = 0;
        chk("R5 soft ignored", checkstop, 1);
        chk("R5 soft no vector", vec_valid, 0);
        ins_valid = 1; ins_illegal = 1; step(); ins_valid = 0; ins_illegal = 0;
        chk("R5 fault ignored", vec_valid, 0);
        hard_rst_req = 1; step(); hard_rst_req = 0;
        chk("R5 exit", checkstop, 0);
        chk("R5 exit vector", vec_addr, BASE | 32'h100);
        chk("R5 exit valid", vec_valid, 1);
        chk("R5 stall released", dispatch_stall, 0);
    endtask

    task automatic t_ext();
        msr_set(6'h22);
        resume_pc = 32'h2000;
        ext_irq = 1; step();
        chk("R7 stall", dispatch_stall, 1);
        chk("R7 drain_req", drain_req, 1);
        chk("R7 no vector yet", vec_valid, 0);
        step();
        chk("R7 still draining", vec_valid, 0);
        drain_done = 1; step(); drain_done = 0;
        chk("R7 vector", vec_addr, BASE | 32'h500);
        chk("R7 valid", vec_valid, 1);
        chk("R7 srr0", srr0, 32'h2000);
        chk("R7 srr1", srr1, 12'h022);
        chk("R6 msr", msr, 6'h00);
        chk("R7 drain released", drain_req, 0);
        ext_irq = 0;
        resume_pc = 32'h1000;
    endtask

    task automatic t_drain_fault();
        msr_set(6'h22);
        ext_irq = 1; step();
        chk("R8 draining", drain_req, 1);
        ins_valid = 1; ins_trap = 1; ins_pc = 32'h3000; drain_done = 1;
        step();
        ins_valid = 0; ins_trap = 0; drain_done = 0;
        chk("R8 fault wins", vec_addr, BASE | 32'h700);
        chk("R8 srr0", srr0, 32'h3000);
        chk("R8 srr1 trap", srr1, 12'h122);
        chk("R8 back to run", drain_req, 0);
        step();
        chk("R11 masked ext no drain", dispatch_stall, 0);
        chk("R11 masked ext no vector", vec_valid, 0);
        ext_irq = 0;
    endtask

    task automatic t_program();
        msr_set(6'h3F);
        ins_valid = 1; ins_illegal = 1; ins_pc = 32'h4000; step();
        idle();
        chk("R9 illegal vector", vec_addr, BASE | 32'h700);
        chk("R9 illegal srr1", srr1, 12'h43F);
        chk("R6 FE kept", msr, 6'h0C);
        chk("R9 srr0", srr0, 32'h4000);
        msr_set(6'h00);
        ins_valid = 1; ins_priv_op = 1; step(); idle();
        chk("R9 priv in supervisor", vec_valid, 0);
        msr_set(6'h10);
        ins_valid = 1; ins_spr_move = 1; step(); idle();
        chk("R9 spr low bit", vec_valid, 0);
        ins_valid = 1; ins_spr_move = 1; ins_spr_top = 1; step(); idle();
        chk("R9 spr top priv", vec_valid, 1);
        chk("R9 priv srr1", srr1, 12'h210);
        msr_set(6'h04);
        ins_valid = 1; fp_fex = 1; step(); idle();
        chk("R9 fpe vector", vec_addr, BASE | 32'h700);
        chk("R9 fpe srr1", srr1, 12'h804);
        msr_set(6'h00);
        ins_valid = 1; fp_fex = 1; step(); idle();
        chk("R9 fpe masked", vec_valid, 0);
        ins_valid = 1; ins_fp_off = 1; step(); idle();
        chk("R2 fp unavailable", vec_addr, BASE | 32'h800);
        chk("R2 fp unavailable srr1", srr1, 12'h000);
    endtask

    task automatic t_priority();
        msr_set(6'h22);
        soft_rst_req = 1; mchk_pin = 1; ins_valid = 1; ins_illegal = 1; ext_irq = 1;
        step(); idle();
        chk("R11 reset first", vec_addr, BASE | 32'h100);
        msr_set(6'h22);
        mchk_pin = 1; ins_valid = 1; ins_illegal = 1; step(); idle();
        chk("R11 mchk over program", vec_addr, BASE | 32'h200);
        msr_set(6'h22);
        ins_valid = 1; ins_illegal = 1; ins_fp_off = 1; step(); idle();
        chk("R11 program over fpu", vec_addr, BASE | 32'h700);
    endtask

    task automatic t_dec();
        msr_set(6'h02);
        dec_req = 1; step(); dec_req = 0;
        step();
        chk("R12 masked no stall", dispatch_stall, 0);
        chk("R12 masked no vector", vec_valid, 0);
        msr_set(6'h22);
        step();
        chk("R12 pending drains", drain_req, 1);
        drain_done = 1; step(); drain_done = 0;
        chk("R12 dec vector", vec_addr, BASE | 32'h900);
        chk("R12 dec valid", vec_valid, 1);
        msr_set(6'h22);
        step();
        chk("R12 pending cleared", dispatch_stall, 0);
    endtask

    task automatic t_lost();
        msr_set(6'h03);
        state_lost = 1; soft_rst_req = 1; step(); idle();
        chk("R10 RI cleared", srr1, 12'h002);
        msr_set(6'h03);
        state_lost = 1; ins_valid = 1; ins_illegal = 1; step(); idle();
        chk("R10 RI kept for program", srr1, 12'h403);
    endtask

    initial begin
        idle();
        ins_pc = '0;
        resume_pc = 32'h1000;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset_state();
        t_resets();
        t_mchk();
        t_ckstop();
        t_ext();
        t_drain_fault();
        t_program();
        t_priority();
        t_dec();
        t_lost();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule